// File: doc/BRIEF.md
# Serial Controller-ID Contention Node

This block is the per-chip half of a contention scheme that hands one controller ID to exactly one chip per pass. Every chip on a shared open-drain style line, whose idle level is 1 and whose active level is 0, takes part in a bit-serial contest. The chip builds a 36-bit key from its own identity fields and puts the key on the line one bit per strobe, starting at index 0. After each bit it reads back the resolved line. If the line differs from the bit it put out, it stops driving and withdraws from the contest. The chip that survives all 36 bits has the lowest key, in the sense that a 0 wins at the first bit where two keys differ. That chip stores the ID offered on the bus.

A chip that already holds an ID stays out of every later pass. A system controller therefore issues one start pulse per pass and repeats passes until every chip is numbered. A synchronous reset takes the stored ID away.

Top module: `cid_arb_node`

## Requirements
- R1: While and right after reset, `drive_o`=1, `active_o`=0, `win_o`=0, `cid_valid_o`=0 and `cid_o`=0.
- R2: The key is `{node_id, part_no, mfr_code, 1'b0}`. Key bit 0 is always 0, bits 11:1 carry `mfr_code`, bits 27:12 carry `part_no` and bits 35:28 carry `node_id`. While participating, `drive_o` shows the key bit at the current index.
- R3: A `start` pulse on a chip without an ID sets `active_o` and sets the index to 0 in the following cycle. `drive_o` then shows key bit 0.
- R4: While `active_o`=0, `drive_o` is 1, the idle line level.
- R5: On a `bit_stb` while participating, if `line_in` differs from the key bit at the current index, `active_o` falls in the next cycle and `drive_o` returns to 1.
- R6: On a `bit_stb` while participating, if `line_in` matches and the index is below 35, the index advances by one. `drive_o` shows the next key bit in the next cycle.
- R7: A match at index 35 raises `win_o` for exactly one cycle. In that same cycle `cid_o` equals the `cid_in` sampled at the strobe, `cid_valid_o`=1 and `active_o`=0.
- R8: A chip with `cid_valid_o`=1 ignores `start`. `active_o` stays 0 and `drive_o` stays 1.
- R9: A `start` pulse in the middle of a contest restarts it at index 0. If `start` and `bit_stb` arrive in the same cycle, `start` takes priority.
- R10: A `bit_stb` while not participating changes no output.
- R11: Reset clears a stored ID and its valid flag. After reset the chip can compete again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | 8 | Node identity field, upper part of the key |
| part_no | input | 16 | Part identity field |
| mfr_code | input | 11 | Maker identity field |
| start | input | 1 | Begins a contest pass |
| bit_stb | input | 1 | Marks the cycle in which the resolved line is valid for the current bit |
| line_in | input | 1 | Resolved value of the shared line |
| cid_in | input | 4 | ID offered to the winner of this pass |
| drive_o | output | 1 | Bit this chip places on the shared line, 1 when idle |
| active_o | output | 1 | Chip is still in the contest |
| win_o | output | 1 | One-cycle pulse when this chip wins |
| cid_o | output | 4 | Stored ID |
| cid_valid_o | output | 1 | Stored ID is valid |

## Verification
The bench builds the block with its default widths: an 8-bit node field, a 16-bit part field, an 11-bit maker field and a 4-bit ID. With these widths every bench run walks the full 36-bit key, so the final-bit win and the latching of the ID are covered, not a shortened stand-in. A modelled rival that pulls the line low at key index 5 forces a loss partway through a pass. Restart and ignore cases then run at the same widths against a chip that holds an ID and against one that does not.

// File: rtl/cid_arb_pkg.sv
package cid_arb_pkg;

    // Idle (undriven) level of the shared line
    localparam logic LINE_IDLE = 1'b1;

    // Per-strobe outcome produced by the sequencer
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_STEP = 2'd1,
        EV_LOSE = 2'd2,
        EV_WIN  = 2'd3
    } arb_ev_e;

    // Contest phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } arb_ph_e;

    function automatic int key_width(input int nw, input int pw, input int mw);
        return nw + pw + mw + 1;
    endfunction

endpackage

// File: rtl/cid_arb_target.sv
module cid_arb_target #(
    parameter int NODE_W = 8,
    parameter int PART_W = 16,
    parameter int MFR_W  = 11,
    parameter int KEY_W  = cid_arb_pkg::key_width(NODE_W, PART_W, MFR_W),
    parameter int IX_W   = $clog2(KEY_W)
) (
    input  logic [NODE_W-1:0] node_id,
    input  logic [PART_W-1:0] part_no,
    input  logic [MFR_W-1:0]  mfr_code,
    input  logic [IX_W-1:0]   idx,
    output logic              key_bit
);
    logic [KEY_W-1:0] key;

    // Identity fields with a trailing zero in bit 0
    assign key = {node_id, part_no, mfr_code, 1'b0};

    always_comb begin
        if (32'(idx) < KEY_W) key_bit = key[idx];
        else                  key_bit = cid_arb_pkg::LINE_IDLE;
    end
endmodule

// File: rtl/cid_arb_seq.sv
module cid_arb_seq
    import cid_arb_pkg::*;
#(
    parameter int KEY_W = 36,
    parameter int IX_W  = $clog2(KEY_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            bit_stb,
    input  logic            line_in,
    input  logic            key_bit,
    input  logic            have_cid,
    output logic            active,
    output logic [IX_W-1:0] idx,
    output arb_ev_e         ev,
    output logic            win_q
);
    localparam logic [IX_W-1:0] LAST_IX = IX_W'(KEY_W - 1);

    arb_ph_e ph_q;

    // Outcome of this cycle's strobe (ignored when start is present)
    always_comb begin
        ev = EV_NONE;
        if (!start && bit_stb && ph_q == PH_RUN) begin
            if (line_in != key_bit) ev = EV_LOSE;
            else if (idx == LAST_IX) ev = EV_WIN;
            else ev = EV_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            idx   <= '0;
            win_q <= 1'b0;
        end else begin
            win_q <= (ev == EV_WIN);
            if (start) begin
                idx <= '0;
                if (!have_cid) ph_q <= PH_RUN;
            end else begin
                case (ev)
                    EV_STEP: idx  <= idx + 1'b1;
                    EV_LOSE: ph_q <= PH_IDLE;
                    EV_WIN:  ph_q <= PH_IDLE;
                    default: ;
                endcase
            end
        end
    end

    assign active = (ph_q == PH_RUN);
endmodule

// File: rtl/cid_arb_store.sv
module cid_arb_store #(
    parameter int CID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CID_W-1:0] cid_in,
    output logic [CID_W-1:0] cid_q,
    output logic             valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cid_q   <= '0;
            valid_q <= 1'b0;
        end else if (take) begin
            cid_q   <= cid_in;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cid_arb_node.sv
module cid_arb_node
    import cid_arb_pkg::*;
#(
    parameter int NODE_W = 8,
    parameter int PART_W = 16,
    parameter int MFR_W  = 11,
    parameter int CID_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODE_W-1:0] node_id,
    input  logic [PART_W-1:0] part_no,
    input  logic [MFR_W-1:0]  mfr_code,
    input  logic              start,
    input  logic              bit_stb,
    input  logic              line_in,
    input  logic [CID_W-1:0]  cid_in,
    output logic              drive_o,
    output logic              active_o,
    output logic              win_o,
    output logic [CID_W-1:0]  cid_o,
    output logic              cid_valid_o
);
    localparam int KEY_W = key_width(NODE_W, PART_W, MFR_W);
    localparam int IX_W  = $clog2(KEY_W);

    logic            key_bit;
    logic            active;
    logic [IX_W-1:0] idx;
    arb_ev_e         ev;

    cid_arb_target #(
        .NODE_W(NODE_W), .PART_W(PART_W), .MFR_W(MFR_W),
        .KEY_W(KEY_W), .IX_W(IX_W)
    ) u_target (
        .node_id (node_id),
        .part_no (part_no),
        .mfr_code(mfr_code),
        .idx     (idx),
        .key_bit (key_bit)
    );

    cid_arb_seq #(.KEY_W(KEY_W), .IX_W(IX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bit_stb (bit_stb),
        .line_in (line_in),
        .key_bit (key_bit),
        .have_cid(cid_valid_o),
        .active  (active),
        .idx     (idx),
        .ev      (ev),
        .win_q   (win_o)
    );

    cid_arb_store #(.CID_W(CID_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .take   (ev == EV_WIN),
        .cid_in (cid_in),
        .cid_q  (cid_o),
        .valid_q(cid_valid_o)
    );

    assign active_o = active;
    assign drive_o  = active ? key_bit : LINE_IDLE;
endmodule

// File: rtl/cid_arb_chk.sv
module cid_arb_chk #(
    parameter int CID_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             bit_stb,
    input logic             line_in,
    input logic [CID_W-1:0] cid_in,
    input logic             drive_o,
    input logic             active_o,
    input logic             win_o,
    input logic [CID_W-1:0] cid_o,
    input logic             cid_valid_o
);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> drive_o);

    // R5
    drop_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (active_o && bit_stb && !start && (line_in != drive_o)) |=> !active_o);

    // R7
    win_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (active_o && bit_stb && !start && (line_in == drive_o)) ##1 win_o
            |-> (cid_valid_o && !active_o && cid_o == $past(cid_in)));

    // R7
    win_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        win_o |=> !win_o);

    // R8
    holder_out_chk: assert property (@(posedge clk) disable iff (rst)
        cid_valid_o |-> !active_o);

    // R11
    cid_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cid_valid_o |=> (cid_valid_o && $stable(cid_o)));
endmodule

bind cid_arb_node cid_arb_chk #(.CID_W(CID_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .bit_stb(bit_stb),
    .line_in(line_in), .cid_in(cid_in), .drive_o(drive_o),
    .active_o(active_o), .win_o(win_o), .cid_o(cid_o),
    .cid_valid_o(cid_valid_o)
);

// File: tb/sim_cid_arb_node.sv
`timescale 1ns/1ps
module sim_cid_arb_node;
    localparam int NW = 8, PW = 16, MW = 11, CW = 4, KW = NW + PW + MW + 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, start = 1'b0, bit_stb = 1'b0, line_in = 1'b1;
    logic [NW-1:0] node_id = 8'h3C;
    logic [PW-1:0] part_no = 16'hA5C3;
    logic [MW-1:0] mfr_code = 11'h5B5;
    logic [CW-1:0] cid_in = '0;
    logic          drive_o, active_o, win_o, cid_valid_o;
    logic [CW-1:0] cid_o;

    cid_arb_node u0 (
        .clk(clk), .rst(rst), .node_id(node_id), .part_no(part_no),
        .mfr_code(mfr_code), .start(start), .bit_stb(bit_stb),
        .line_in(line_in), .cid_in(cid_in), .drive_o(drive_o),
        .active_o(active_o), .win_o(win_o), .cid_o(cid_o),
        .cid_valid_o(cid_valid_o)
    );

    typedef struct {
        logic          drv, act, win, val;
        logic [CW-1:0] cid;
        string         tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;

    // Reference state built from the requirements
    logic [KW-1:0] key;
    logic          m_act = 0, m_win = 0, m_val = 0;
    logic [CW-1:0] m_cid = '0;
    int            m_idx = 0;

    // Driver: applies one cycle of stimulus and queues the outputs due after the edge
    task automatic cyc(input logic r, input logic st, input logic stb,
                       input logic rival, input logic [CW-1:0] c, input string tag);
        logic own, ln;
        exp_t e;
        @(negedge clk);
        key = {node_id, part_no, mfr_code, 1'b0};
        own = m_act ? key[m_idx] : 1'b1;
        // rival pulls the line low at index 5
        ln  = own & ~(rival && m_idx == 5);
        rst = r; start = st; bit_stb = stb; line_in = ln; cid_in = c;
        if (r) begin
            m_act = 0; m_idx = 0; m_val = 0; m_cid = '0; m_win = 0;
        end else begin
            m_win = 0;
            if (st) begin
                m_idx = 0;
                if (!m_val) m_act = 1;
            end else if (stb && m_act) begin
                if (ln != key[m_idx]) m_act = 0;
                else if (m_idx == KW - 1) begin
                    m_win = 1; m_val = 1; m_cid = c; m_act = 0;
                end else m_idx++;
            end
        end
        e.drv = m_act ? key[m_idx] : 1'b1;
        e.act = m_act; e.win = m_win; e.val = m_val; e.cid = m_cid; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares outputs one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (drive_o !== e.drv || active_o !== e.act || win_o !== e.win ||
                    cid_valid_o !== e.val || cid_o !== e.cid) begin
                    errors++;
                    $display("FAIL %s: got drv=%b act=%b win=%b val=%b cid=%h exp drv=%b act=%b win=%b val=%b cid=%h",
                             e.tag, drive_o, active_o, win_o, cid_valid_o, cid_o,
                             e.drv, e.act, e.win, e.val, e.cid);
                end
            end
        end
    end

    task automatic stimulus();
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R1 reset state");
        cyc(0, 0, 0, 0, 0, "R4 idle drive");
        cyc(0, 0, 1, 0, 0, "R10 strobe while idle");
        // lone chip walks the whole key and wins
        cyc(0, 1, 0, 0, 0, "R3 start");
        for (int i = 0; i < KW; i++)
            cyc(0, 0, 1, 0, 4'hA, (i == KW - 1) ? "R7 win at last bit" : "R2 R6 key bit walk");
        cyc(0, 0, 0, 0, 4'h5, "R7 win pulse ends");
        // holder ignores new passes
        cyc(0, 1, 0, 0, 0, "R8 start ignored");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'h3, "R8 R10 holder keeps id");
        // reset clears and chip competes again, losing to a rival
        cyc(1, 0, 0, 0, 0, "R11 reset clears id");
        cyc(0, 1, 0, 0, 0, "R11 R3 start after clear");
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, 1, 4'h6, "R5 rival contest");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 4'h6, "R10 strobe after loss");
        // restart mid-contest, start and strobe together
        cyc(0, 1, 0, 0, 0, "R3 start");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 4'h2, "R6 step");
        cyc(0, 1, 1, 0, 4'h2, "R9 start over strobe");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'h2, "R9 walk after restart");
        cyc(0, 0, 0, 0, 0, "R9 idle");
        repeat (3) @(posedge clk);
    endtask

    initial begin
        bit hung = 0;
        fork
            stimulus();
            begin repeat (20000) @(posedge clk); hung = 1; end
        join_any
        disable fork;
        if (hung) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule